// File: doc/BRIEF.md
# Maskable interrupt status unit

This unit collects eight event lines from a serial memory controller into a sticky raw status register. Each event line is a single-cycle pulse. A bit that gets set stays set until software clears it. An enable mask selects which latched events drive the single level-sensitive interrupt output. A masked view of the status lets the handler see only the causes that are enabled. Events latch whether or not they are enabled, so software can also poll a bit, for example the DMA-done bit, with the interrupt disabled.

A recovery register holds one self-clearing bit. Writing a one to it raises a reset request to the transaction sequencer and the FIFOs for a fixed number of cycles. Software polls the bit until it reads zero again.

All registers sit behind a word-wide register port. A write takes effect on the clock edge where `req_i` and `we_i` are both high. Read data is combinational from `addr_i`. Word addresses: 0 enable mask, 1 clear, 2 raw status, 3 masked status, 4 recovery.

Top module: `irq_stat_unit`

## Requirements
- R1: A pulse on `evt_i[k]` sets raw status bit k at the next clock edge, whatever the mask holds. The bit order is: 0 receive full, 1 receive underflow, 2 transmit overflow, 3 transmit empty, 4 transfer finished, 5 bus error, 6 non-serial error, 7 DMA done.
- R2: A raw status bit stays set until it is cleared. A raw status bit is only ever set by its event line.
- R3: Writing to address 1 clears each raw bit whose `wdata_i` bit is one and leaves all other raw bits unchanged. Writing all ones clears every bit.
- R4: If an event and a clear hit the same bit on the same edge, the bit ends up set.
- R5: Address 0 reads and writes the mask in bits [7:0]. Address 3 reads raw status AND mask. The mask, clear, raw and masked registers all use the R1 bit order.
- R6: `irq_o` is high exactly when at least one raw bit is set and its mask bit is also set.
- R7: After reset, the raw status is zero, the mask is zero, `irq_o` is low and recovery is idle.
- R8: Writing 1 to bit 0 of address 4 raises `recover_o`, which also reads back as bit 0 of address 4, for exactly RECOVER_CYCLES cycles. The bit then clears itself. Recovery does not change the raw status or the mask.
- R9: Writing to address 4 while recovery is running does not extend it. Writing 0 to bit 0 of address 4 does not start recovery.
- R10: Writes to addresses 2, 3 and to addresses above 4 change no state. Address 1 and unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_EVT | Event pulses, one per source |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Word address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |
| recover_o | output | 1 | Reset request to the sequencer and the FIFOs |

## Verification
On every cycle, the assertions check how each raw bit moves: events set their bit, clears remove only the bits they target, a simultaneous event wins over a clear, and no bit appears without an event. They also check that the interrupt matches the enabled status and that each recovery pulse lasts exactly RECOVER_CYCLES cycles. Only the bench scenarios can show the register map at work. That means the address decode, the mask readback, the ignored writes to read-only addresses, the zero reads from address 1, and how recovery responds to repeated or zero writes. The bench compares every read against its reference model.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] A_MASK   = 3'd0;
  localparam logic [REG_AW-1:0] A_CLEAR  = 3'd1;
  localparam logic [REG_AW-1:0] A_RAW    = 3'd2;
  localparam logic [REG_AW-1:0] A_MASKED = 3'd3;
  localparam logic [REG_AW-1:0] A_RECOV  = 3'd4;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] clr_i,
  output logic [N_EVT-1:0] raw_o
);
  for (genvar k = 0; k < N_EVT; k++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (evt_i[k]) q <= 1'b1;  // set beats clear
      else if (clr_i[k]) q <= 1'b0;
    end
    assign raw_o[k] = q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_EVT-1:0] wdata_i,
  output logic [N_EVT-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_recover_seq.sv
module irq_recover_seq #(
  parameter int unsigned RECOVER_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(RECOVER_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RECOVER_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= LOAD;
    end
  end
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_stat_pkg::*;
#(
  parameter int unsigned N_EVT          = 8,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned ADDR_W         = REG_AW,
  parameter int unsigned RECOVER_CYCLES = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              recover_o
);
  logic              wr_en;
  logic [N_EVT-1:0]  clr_bits;
  logic [N_EVT-1:0]  raw_bits;
  logic [N_EVT-1:0]  mask_bits;
  logic [N_EVT-1:0]  masked_bits;
  logic              rec_busy;
  logic              mask_wr;
  logic              rec_start;

  assign wr_en     = req_i && we_i;
  assign mask_wr   = wr_en && (addr_i == ADDR_W'(A_MASK));
  assign clr_bits  = (wr_en && addr_i == ADDR_W'(A_CLEAR)) ? wdata_i[N_EVT-1:0] : '0;
  assign rec_start = wr_en && (addr_i == ADDR_W'(A_RECOV)) && wdata_i[0];

  irq_sticky_bank #(.N_EVT(N_EVT)) i_bank (
    .clk_i (clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .clr_i(clr_bits), .raw_o(raw_bits)
  );

  irq_mask_reg #(.N_EVT(N_EVT)) i_mask (
    .clk_i (clk_i), .rst_ni(rst_ni), .wr_i(mask_wr), .wdata_i(wdata_i[N_EVT-1:0]),
    .mask_o(mask_bits)
  );

  irq_recover_seq #(.RECOVER_CYCLES(RECOVER_CYCLES)) i_recov (
    .clk_i (clk_i), .rst_ni(rst_ni), .start_i(rec_start), .busy_o(rec_busy)
  );

  assign masked_bits = raw_bits & mask_bits;
  assign irq_o       = |masked_bits;
  assign recover_o   = rec_busy;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(A_MASK):   rdata_o[N_EVT-1:0] = mask_bits;
      ADDR_W'(A_RAW):    rdata_o[N_EVT-1:0] = raw_bits;
      ADDR_W'(A_MASKED): rdata_o[N_EVT-1:0] = masked_bits;
      ADDR_W'(A_RECOV):  rdata_o[0]         = rec_busy;
      default:           rdata_o            = '0;
    endcase
  end
endmodule

// File: rtl/irq_stat_unit_chk.sv
module irq_stat_unit_chk #(
  parameter int unsigned N_EVT          = 8,
  parameter int unsigned RECOVER_CYCLES = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_EVT-1:0] evt_i,
  input logic [N_EVT-1:0] clr_bits,
  input logic [N_EVT-1:0] raw_bits,
  input logic [N_EVT-1:0] mask_bits,
  input logic             rec_busy,
  input logic             irq_o
);
  logic [31:0] run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_cnt <= '0;
    else if (rec_busy) run_cnt <= run_cnt + 1;
    else               run_cnt <= '0;
  end

  a_r1_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((raw_bits & $past(evt_i)) == $past(evt_i)));

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_bits == '0) |=> ((raw_bits & $past(raw_bits)) == $past(raw_bits)));

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0) |=> ((raw_bits & ~$past(raw_bits)) == '0));

  a_r3_clear_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_bits != '0) |=> ((raw_bits & $past(clr_bits & ~evt_i)) == '0));

  a_r6_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((raw_bits & mask_bits) != '0));

  a_r6_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> ((raw_bits & mask_bits) == '0));

  a_r8_max_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_busy |-> (run_cnt < RECOVER_CYCLES));

  a_r8_exact_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rec_busy) |-> (run_cnt == RECOVER_CYCLES));
endmodule

bind irq_stat_unit irq_stat_unit_chk #(.N_EVT(N_EVT), .RECOVER_CYCLES(RECOVER_CYCLES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .clr_bits(clr_bits),
  .raw_bits(raw_bits), .mask_bits(mask_bits), .rec_busy(rec_busy), .irq_o(irq_o)
);

// File: tb/test_irq_stat_unit.sv
module test_irq_stat_unit;
  localparam int NE = 8;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int RC = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NE-1:0] evt = '0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  logic          recover;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_stat_unit #(.N_EVT(NE), .DATA_W(DW), .ADDR_W(AW), .RECOVER_CYCLES(RC)) i_irq_stat_unit (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .recover_o(recover)
  );

  // reference model
  int m_raw = 0, m_mask = 0, m_cnt = 0;
  bit m_busy = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_raw = 0; m_mask = 0; m_busy = 0; m_cnt = 0;
    end else begin
      int clr;
      clr = (req && we && addr == 1) ? int'(wdata[NE-1:0]) : 0;
      m_raw = (m_raw & ~clr) | int'(evt);
      if (req && we && addr == 0) m_mask = int'(wdata[NE-1:0]);
      if (m_busy) begin
        if (m_cnt == 1) m_busy = 0;
        else m_cnt = m_cnt - 1;
      end else if (req && we && addr == 4 && wdata[0]) begin
        m_busy = 1; m_cnt = RC;
      end
    end
  end

  function automatic int model_rd(int a);
    case (a)
      0: return m_mask;
      2: return m_raw;
      3: return m_raw & m_mask;
      4: return int'(m_busy);
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "rdata", int'(rdata), model_rd(int'(addr)));
    check(tag, "irq", int'(irq), int'((m_raw & m_mask) != 0));
    check(tag, "recover", int'(recover), int'(m_busy));
  endtask

  // drive at negedge, let one edge pass, compare at next negedge
  task automatic cyc(string tag, logic [NE-1:0] e, logic r, logic w, int a, logic [DW-1:0] d);
    evt = e; req = r; we = w; addr = AW'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rd(string tag, int a);
    cyc(tag, '0, 1'b1, 1'b0, a, '0);
  endtask

  task automatic wr(string tag, int a, logic [DW-1:0] d);
    cyc(tag, '0, 1'b1, 1'b1, a, d);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R7");
    rst_ni = 1'b1;
    @(negedge clk);
    rd("R7", 2);
    check("R7", "raw", int'(rdata), 0);
    rd("R7", 0);
    check("R7", "mask", int'(rdata), 0);

    // R1: each source latches with mask clear
    for (int k = 0; k < NE; k++) begin
      cyc("R1", NE'(1) << k, 1'b0, 1'b0, 2, '0);
      rd("R1", 2);
      check("R1", "raw bit", int'(rdata[k]), 1);
      check("R1", "irq masked", int'(irq), 0);
    end
    // R2: sticky over idle cycles
    repeat (4) rd("R2", 2);
    check("R2", "raw all", int'(rdata), 'hff);
    // R3: partial then full clear
    wr("R3", 1, 32'h0000_000f);
    rd("R3", 2);
    check("R3", "partial", int'(rdata), 'hf0);
    wr("R3", 1, 32'hffff_ffff);
    rd("R3", 2);
    check("R3", "full", int'(rdata), 0);
    // R5/R6: mask and masked view
    wr("R5", 0, 32'h0000_0081);
    rd("R5", 0);
    check("R5", "mask rb", int'(rdata), 'h81);
    cyc("R6", 8'h02, 1'b0, 1'b0, 3, '0);
    check("R6", "irq off", int'(irq), 0);
    cyc("R6", 8'h80, 1'b0, 1'b0, 3, '0);
    check("R6", "irq on", int'(irq), 1);
    check("R5", "masked", int'(rdata), 'h80);
    // R4: set wins over clear
    cyc("R4", 8'h80, 1'b1, 1'b1, 1, 32'h0000_0082);
    rd("R4", 2);
    check("R4", "set wins", int'(rdata), 'h80);
    // R10: ignored writes, zero reads
    wr("R10", 2, 32'h0);
    wr("R10", 3, 32'h0);
    wr("R10", 6, 32'hffff_ffff);
    rd("R10", 2);
    check("R10", "raw kept", int'(rdata), 'h80);
    rd("R10", 1);
    check("R10", "clear reads 0", int'(rdata), 0);
    rd("R10", 7);
    check("R10", "unused 0", int'(rdata), 0);
    // R9: zero write does nothing
    wr("R9", 4, 32'hffff_fffe);
    check("R9", "no start", int'(recover), 0);
    // R8: recovery pulse length, status untouched
    wr("R8", 4, 32'h1);
    begin
      int len = 1;
      while (recover && len < 50) begin
        if (len == 2) wr("R9", 4, 32'h1);
        else rd("R8", 4);
        if (recover) len++;
      end
      check("R8", "pulse length", len, RC);
      check("R9", "not extended", len, RC);
    end
    rd("R8", 2);
    check("R8", "raw kept", int'(rdata), 'h80);
    rd("R8", 0);
    check("R8", "mask kept", int'(rdata), 'h81);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [NE-1:0] e;
      int a;
      e = ($urandom % 4 == 0) ? NE'($urandom) : '0;
      a = $urandom % 8;
      cyc("R1", e, 1'($urandom), 1'($urandom), a, $urandom);
    end
    wr("R3", 1, 32'hffff_ffff);
    rd("R3", 2);
    check("R3", "final clear", int'(rdata), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule